// File: doc/BRIEF.md
# Flash Command Controller with Sector Protection

This block sits between a microcontroller bus and a small behavioural flash array. It watches the bus for write cycles and turns them into flash operations. An operation starts only after two unlock writes. The operations are byte program, sector erase, bulk erase and entry into an identification/protection readout mode. A reset command leaves that readout mode, clears a latched error, and cuts a running sector erase short. Program and erase take a fixed number of clock cycles each. While one runs, the controller reports busy and array reads return a status byte.

Each of the eight primary sectors and four secondary sectors has a write-protect bit. These bits come from a configuration path outside this block. The bus can read them through two register views but can never change them. A program or erase aimed at a protected sector is dropped without any trace, so reading that sector back still gives the old contents. A separate hardware reset pin stops any running operation. A failed operation raises an error bit, bit 5 of the status byte, and that bit stays set until it is cleared.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), `busy` is 0, and every array byte reads FFh.
- R2: A program runs when the bus writes AAh at 555h, then 55h at AAAh, then A0h at 555h, then the data at the target address. While it runs, `mode` is 2 and `busy` is 1 for PROG_CYCLES cycles. At the end the target byte becomes the old value AND the written data.
- R3: If either unlock write has the wrong data or the wrong address, the decoder returns to idle. A command byte that follows then has no effect.
- R4: The sector is address bits [5:2]. Sectors 0..7 take their protect bit from `prot_cfg[7:0]` and sectors 8..11 from `prot_cfg[11:8]`, where 1 means protected. A program or sector erase aimed at a protected sector is ignored, and so is one aimed at an address of 30h or above. An ignored command leaves `busy` at 0, `mode` at 0 and the array byte unchanged.
- R5: A sector erase is AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, then 30h at any address in the sector. It keeps `busy` high for SERASE_CYCLES cycles, then sets every byte of that sector to FFh and leaves other sectors untouched.
- R6: A bulk erase uses the same five setup writes, then 10h at 555h. It keeps `busy` high for BERASE_CYCLES cycles, then sets every unprotected sector to FFh and keeps the protected ones.
- R7: 90h at 555h after the unlock pair sets `mode` to 1. In that mode an array read at offset 0, 1, 2 or 3 (`bus_addr[1:0]`) returns MFR_ID, DEV_ID, register A or register B. Any command other than reset is ignored until reset.
- R8: With `csr_sel` high, a read with `bus_addr[0]`=0 returns register A, which is `prot_cfg[7:0]`. A read with `bus_addr[0]`=1 returns register B: bit 7 is `security_bit`, bits 6..4 read 0 and bits 3..0 are `prot_cfg[11:8]`. A write with `csr_sel` high is ignored, including by the command decoder.
- R9: A write of F0h is the reset command. It is accepted on its own or after the unlock pair. It returns readout mode to read mode on the next cycle. It is ignored during a program or a bulk erase, which then run for their full time and update the array.
- R10: A reset command during a sector erase stops it. The block then stays busy for RECOVERY_CYCLES cycles, returns to read mode, and the sector keeps its old contents.
- R11: If `fail_inject` is high in the final cycle of an operation, the array is left unchanged and `mode` becomes 3 with `busy` at 0. The block stays there, whatever other writes arrive, until a reset command. That command starts a recovery of RECOVERY_CYCLES cycles that ends in read mode.
- R12: A `hw_rst` pulse during a program or erase stops it, with no array change, and starts a recovery of RECOVERY_CYCLES cycles. In readout mode or error mode it returns the block to read mode on the next cycle.
- R13: When `mode` is 2 or 3, an array read returns a status byte. Bit 7 is `busy`, bit 5 is the error flag (1 only in mode 3), and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst | input | 1 | Hardware reset pulse that aborts operations |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| csr_sel | input | 1 | Selects the protection register view |
| bus_addr | input | 12 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data (array, readout, register or status) |
| prot_cfg | input | 12 | Per-sector protect bits from the configuration path |
| security_bit | input | 1 | Device security flag shown in register B |
| fail_inject | input | 1 | Forces the running operation to fail at completion |
| mode | output | 2 | 0 read, 1 readout, 2 busy, 3 error |
| busy | output | 1 | High while an operation or recovery runs |

## Verification
The reset command is issued during a program, a bulk erase and a sector erase, and the busy time is counted each time. A design that treated reset the same way in every case would either cut the program short or let the erase finish and wipe the sector. Protected sectors are given non-erased contents by lifting protection for a moment, so a bulk erase that ignored protection would show up as FFh there. Bad unlock data, a bad unlock address and writes through the register view are each followed by a command byte. A decoder that kept partial progress would then enter readout mode or start a program. The error state is probed with other writes and with the hardware pin, to catch a flag that clears too early or a recovery that is skipped.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] UNLOCK_ADDR_1 = 12'h555;
    localparam logic [ADDR_W-1:0] UNLOCK_ADDR_2 = 12'hAAA;
    localparam logic [7:0] KEY_1      = 8'hAA;
    localparam logic [7:0] KEY_2      = 8'h55;
    localparam logic [7:0] OPC_PROG   = 8'hA0;
    localparam logic [7:0] OPC_ERASE  = 8'h80;
    localparam logic [7:0] OPC_READID = 8'h90;
    localparam logic [7:0] OPC_SECT   = 8'h30;
    localparam logic [7:0] OPC_BULK   = 8'h10;
    localparam logic [7:0] OPC_RESET  = 8'hF0;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_ID    = 2'd1,
        MODE_BUSY  = 2'd2,
        MODE_ERROR = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PROG   = 3'd1,
        CMD_SERASE = 3'd2,
        CMD_BERASE = 3'd3,
        CMD_ID     = 3'd4,
        CMD_RESET  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        DEC_IDLE = 3'd0,
        DEC_U1   = 3'd1,
        DEC_U2   = 3'd2,
        DEC_PROG = 3'd3,
        DEC_E1   = 3'd4,
        DEC_E2   = 3'd5,
        DEC_E3   = 3'd6
    } dec_e;

    typedef enum logic [2:0] {
        ENG_READ    = 3'd0,
        ENG_ID      = 3'd1,
        ENG_PROG    = 3'd2,
        ENG_SERASE  = 3'd3,
        ENG_BERASE  = 3'd4,
        ENG_RECOVER = 3'd5,
        ENG_ERROR   = 3'd6
    } eng_e;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_PROG   = 2'd1,
        UPD_SECTOR = 2'd2,
        UPD_BULK   = 2'd3
    } upd_e;

    typedef struct packed {
        cmd_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } cmd_t;

    typedef struct packed {
        upd_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } upd_t;

    function automatic logic [7:0] status_byte(input logic busy_f, input logic err_f);
        return {busy_f, 1'b0, err_f, 5'b0};
    endfunction

    function automatic mode_e eng_to_mode(input eng_e st);
        case (st)
            ENG_READ:  return MODE_READ;
            ENG_ID:    return MODE_ID;
            ENG_ERROR: return MODE_ERROR;
            default:   return MODE_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output cmd_t              cmd
);

    dec_e state, nxt;

    logic key1_ok, key2_ok;
    assign key1_ok = (wdata == KEY_1) && (addr == UNLOCK_ADDR_1);
    assign key2_ok = (wdata == KEY_2) && (addr == UNLOCK_ADDR_2);

    always_comb begin
        nxt = state;
        cmd = '0;
        cmd.kind = CMD_NONE;
        if (we) begin
            if (wdata == OPC_RESET && state != DEC_PROG) begin
                cmd.kind = CMD_RESET;
                nxt = DEC_IDLE;
            end else begin
                nxt = DEC_IDLE;
                unique case (state)
                    DEC_IDLE: if (key1_ok) nxt = DEC_U1;
                    DEC_U1:   if (key2_ok) nxt = DEC_U2;
                    DEC_U2: begin
                        if (addr == UNLOCK_ADDR_1) begin
                            if (wdata == OPC_PROG)       nxt = DEC_PROG;
                            else if (wdata == OPC_ERASE) nxt = DEC_E1;
                            else if (wdata == OPC_READID) cmd.kind = CMD_ID;
                        end
                    end
                    DEC_PROG: begin
                        cmd.kind = CMD_PROG;
                        cmd.addr = addr;
                        cmd.data = wdata;
                    end
                    DEC_E1: if (key1_ok) nxt = DEC_E2;
                    DEC_E2: if (key2_ok) nxt = DEC_E3;
                    DEC_E3: begin
                        if (wdata == OPC_SECT) begin
                            cmd.kind = CMD_SERASE;
                            cmd.addr = addr;
                        end else if (wdata == OPC_BULK && addr == UNLOCK_ADDR_1) begin
                            cmd.kind = CMD_BERASE;
                        end
                    end
                    default: nxt = DEC_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) state <= DEC_IDLE;
        else              state <= nxt;
    end

    // R3: a bad second unlock write drops the partial sequence
    a_r3_bad_unlock_idle: assert property (@(posedge clk) disable iff (rst)
        (!clear && we && state == DEC_U1 && !key2_ok && wdata != OPC_RESET)
        |=> state == DEC_IDLE);

    // R2: a command is only ever produced from an unlocked decoder state
    a_r2_cmd_needs_unlock: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_PROG || cmd.kind == CMD_SERASE || cmd.kind == CMD_ID)
        |-> state != DEC_IDLE);

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int NUM_SECT        = 12,
    parameter int WORDS           = 4,
    parameter int PROG_CYCLES     = 4,
    parameter int SERASE_CYCLES   = 20,
    parameter int BERASE_CYCLES   = 40,
    parameter int RECOVERY_CYCLES = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_rst,
    input  cmd_t                cmd,
    input  logic [NUM_SECT-1:0] prot_vec,
    input  logic                fail_inject,
    output eng_e                state,
    output upd_t                upd
);

    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int SEC_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int DEPTH  = NUM_SECT * WORDS;
    localparam int MAXC1  = (PROG_CYCLES > SERASE_CYCLES) ? PROG_CYCLES : SERASE_CYCLES;
    localparam int MAXC2  = (BERASE_CYCLES > RECOVERY_CYCLES) ? BERASE_CYCLES : RECOVERY_CYCLES;
    localparam int MAXC   = (MAXC1 > MAXC2) ? MAXC1 : MAXC2;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PROG_LD = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SER_LD  = CNT_W'(SERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] BER_LD  = CNT_W'(BERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(RECOVERY_CYCLES - 1);

    logic [CNT_W-1:0]      cnt;
    logic [ADDR_W-1:0]     op_addr;
    logic [7:0]            op_data;
    logic [(1<<SEC_W)-1:0] prot_pad;
    logic [SEC_W-1:0]      cmd_sec;
    logic                  cmd_blocked, is_reset, op_active, last;

    always_comb begin
        prot_pad = '1;
        for (int i = 0; i < NUM_SECT; i++) prot_pad[i] = prot_vec[i];
    end

    assign cmd_sec     = cmd.addr[WORD_W +: SEC_W];
    assign cmd_blocked = (cmd.addr >= ADDR_W'(DEPTH)) || prot_pad[cmd_sec];
    assign is_reset    = (cmd.kind == CMD_RESET);
    assign op_active   = (state == ENG_PROG) || (state == ENG_SERASE) || (state == ENG_BERASE);
    assign last        = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_READ;
            cnt     <= '0;
            op_addr <= '0;
            op_data <= '0;
        end else if (hw_rst) begin
            if (op_active) begin
                state <= ENG_RECOVER;
                cnt   <= REC_LD;
            end else if (state != ENG_RECOVER) begin
                state <= ENG_READ;
            end
        end else begin
            unique case (state)
                ENG_READ: begin
                    case (cmd.kind)
                        CMD_PROG: if (!cmd_blocked) begin
                            state   <= ENG_PROG;
                            cnt     <= PROG_LD;
                            op_addr <= cmd.addr;
                            op_data <= cmd.data;
                        end
                        CMD_SERASE: if (!cmd_blocked) begin
                            state   <= ENG_SERASE;
                            cnt     <= SER_LD;
                            op_addr <= cmd.addr;
                        end
                        CMD_BERASE: begin
                            state <= ENG_BERASE;
                            cnt   <= BER_LD;
                        end
                        CMD_ID:  state <= ENG_ID;
                        default: ;
                    endcase
                end
                ENG_ID: if (is_reset) state <= ENG_READ;
                ENG_PROG, ENG_BERASE: begin
                    if (last) state <= fail_inject ? ENG_ERROR : ENG_READ;
                    else      cnt   <= cnt - 1'b1;
                end
                ENG_SERASE: begin
                    if (is_reset) begin
                        state <= ENG_RECOVER;
                        cnt   <= REC_LD;
                    end else if (last) begin
                        state <= fail_inject ? ENG_ERROR : ENG_READ;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_RECOVER: begin
                    if (last) state <= ENG_READ;
                    else      cnt   <= cnt - 1'b1;
                end
                ENG_ERROR: if (is_reset) begin
                    state <= ENG_RECOVER;
                    cnt   <= REC_LD;
                end
                default: state <= ENG_READ;
            endcase
        end
    end

    always_comb begin
        upd = '0;
        upd.kind = UPD_NONE;
        if (!rst && !hw_rst && last && !fail_inject) begin
            if (state == ENG_PROG) begin
                upd.kind = UPD_PROG;
                upd.addr = op_addr;
                upd.data = op_data;
            end else if (state == ENG_SERASE && !is_reset) begin
                upd.kind = UPD_SECTOR;
                upd.addr = op_addr;
            end else if (state == ENG_BERASE) begin
                upd.kind = UPD_BULK;
            end
        end
    end

    // R4: a command aimed at a protected or absent sector leaves the engine idle
    a_r4_blocked_stays_read: assert property (@(posedge clk) disable iff (rst)
        (!hw_rst && state == ENG_READ && cmd_blocked &&
         (cmd.kind == CMD_PROG || cmd.kind == CMD_SERASE)) |=> state == ENG_READ);

    // R9: reset command does not disturb a running program
    a_r9_reset_ignored_prog: assert property (@(posedge clk) disable iff (rst)
        (!hw_rst && state == ENG_PROG && !last && is_reset) |=> state == ENG_PROG);

    // R10: reset command aborts a sector erase into recovery
    a_r10_abort_serase: assert property (@(posedge clk) disable iff (rst)
        (!hw_rst && state == ENG_SERASE && is_reset) |=> state == ENG_RECOVER);

    // R11: error state holds until a reset command or the pin
    a_r11_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (!hw_rst && state == ENG_ERROR && !is_reset) |=> state == ENG_ERROR);

    // R12: the pin sends a running operation into recovery
    a_r12_pin_abort: assert property (@(posedge clk) disable iff (rst)
        (hw_rst && op_active) |=> state == ENG_RECOVER);

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_cmd_pkg::*;
#(
    parameter int NUM_SECT = 12,
    parameter int WORDS    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  upd_t                upd,
    input  logic [NUM_SECT-1:0] prot_vec,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_byte
);

    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int SEC_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int DEPTH  = NUM_SECT * WORDS;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int HI_W   = ADDR_W - WORD_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                mem[i] <= 8'hFF;
            end else begin
                case (upd.kind)
                    UPD_PROG:   if (upd.addr == ADDR_W'(i)) mem[i] <= mem[i] & upd.data;
                    UPD_SECTOR: if (upd.addr[ADDR_W-1:WORD_W] == HI_W'(i / WORDS)) mem[i] <= 8'hFF;
                    UPD_BULK:   if (!prot_vec[i / WORDS]) mem[i] <= 8'hFF;
                    default: ;
                endcase
            end
        end
    end

    assign rd_byte = (rd_addr < ADDR_W'(DEPTH)) ? mem[rd_addr[IDX_W-1:0]] : 8'hFF;

    logic [(1<<SEC_W)-1:0] prot_pad;
    always_comb begin
        prot_pad = '1;
        for (int i = 0; i < NUM_SECT; i++) prot_pad[i] = prot_vec[i];
    end

    // R4: no program or sector erase ever reaches a protected sector
    a_r4_no_protected_write: assert property (@(posedge clk) disable iff (rst)
        (upd.kind == UPD_PROG || upd.kind == UPD_SECTOR)
        |-> !prot_pad[upd.addr[WORD_W +: SEC_W]]);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          NUM_PRI         = 8,
    parameter int          NUM_AUX         = 4,
    parameter int          WORDS           = 4,
    parameter int          PROG_CYCLES     = 4,
    parameter int          SERASE_CYCLES   = 20,
    parameter int          BERASE_CYCLES   = 40,
    parameter int          RECOVERY_CYCLES = 10,
    parameter logic [7:0]  MFR_ID          = 8'h20,
    parameter logic [7:0]  DEV_ID          = 8'hE4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hw_rst,
    input  logic                       bus_we,
    input  logic                       csr_sel,
    input  logic [11:0]                bus_addr,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    input  logic [NUM_PRI+NUM_AUX-1:0] prot_cfg,
    input  logic                       security_bit,
    input  logic                       fail_inject,
    output logic [1:0]                 mode,
    output logic                       busy
);

    localparam int NUM_SECT = NUM_PRI + NUM_AUX;

    cmd_t       cmd;
    upd_t       upd;
    eng_e       state;
    mode_e      mode_q;
    logic [7:0] arr_byte, reg_a, reg_b, id_byte;

    flash_cmd_decoder u_dec (
        .clk   (clk),
        .rst   (rst),
        .clear (hw_rst),
        .we    (bus_we && !csr_sel),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    flash_op_engine #(
        .NUM_SECT        (NUM_SECT),
        .WORDS           (WORDS),
        .PROG_CYCLES     (PROG_CYCLES),
        .SERASE_CYCLES   (SERASE_CYCLES),
        .BERASE_CYCLES   (BERASE_CYCLES),
        .RECOVERY_CYCLES (RECOVERY_CYCLES)
    ) u_eng (
        .clk         (clk),
        .rst         (rst),
        .hw_rst      (hw_rst),
        .cmd         (cmd),
        .prot_vec    (prot_cfg),
        .fail_inject (fail_inject),
        .state       (state),
        .upd         (upd)
    );

    flash_store #(
        .NUM_SECT (NUM_SECT),
        .WORDS    (WORDS)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .prot_vec (prot_cfg),
        .rd_addr  (bus_addr),
        .rd_byte  (arr_byte)
    );

    for (genvar b = 0; b < 8; b++) begin : g_regs
        if (b < NUM_PRI) begin : g_a_live
            assign reg_a[b] = prot_cfg[b];
        end else begin : g_a_zero
            assign reg_a[b] = 1'b0;
        end
        if (b == 7) begin : g_b_sec
            assign reg_b[b] = security_bit;
        end else if (b < NUM_AUX && b < 4) begin : g_b_live
            assign reg_b[b] = prot_cfg[NUM_PRI + b];
        end else begin : g_b_zero
            assign reg_b[b] = 1'b0;
        end
    end

    assign mode_q = eng_to_mode(state);
    assign mode   = mode_q;
    assign busy   = (mode_q == MODE_BUSY);

    always_comb begin
        case (bus_addr[1:0])
            2'd0:    id_byte = MFR_ID;
            2'd1:    id_byte = DEV_ID;
            2'd2:    id_byte = reg_a;
            default: id_byte = reg_b;
        endcase
    end

    always_comb begin
        if (csr_sel) begin
            bus_rdata = bus_addr[0] ? reg_b : reg_a;
        end else begin
            case (mode_q)
                MODE_READ: bus_rdata = arr_byte;
                MODE_ID:   bus_rdata = id_byte;
                default:   bus_rdata = status_byte(busy, mode_q == MODE_ERROR);
            endcase
        end
    end

    // R13: array reads while busy carry the busy bit
    a_r13_status_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !csr_sel) |-> (bus_rdata[7] && !bus_rdata[5]));

    // R11: error mode exposes bit 5 on array reads
    a_r11_dq5_error: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && !csr_sel) |-> (bus_rdata[5] && !busy));

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

    localparam int PROG = 4;
    localparam int SER  = 20;
    localparam int BER  = 40;
    localparam int REC  = 10;
    localparam logic [7:0] MFR = 8'h20;
    localparam logic [7:0] DEV = 8'hE4;

    logic        clk = 1'b0;
    logic        rst, hw_rst, bus_we, csr_sel, security_bit, fail_inject;
    logic [11:0] bus_addr, prot_cfg;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [1:0]  mode;
    logic        busy;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(
        .PROG_CYCLES (PROG), .SERASE_CYCLES (SER), .BERASE_CYCLES (BER),
        .RECOVERY_CYCLES (REC), .MFR_ID (MFR), .DEV_ID (DEV)
    ) u_flash_cmd_ctrl (
        .clk (clk), .rst (rst), .hw_rst (hw_rst), .bus_we (bus_we),
        .csr_sel (csr_sel), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .prot_cfg (prot_cfg), .security_bit (security_bit),
        .fail_inject (fail_inject), .mode (mode), .busy (busy)
    );

    typedef struct packed {
        logic [11:0] a;
        logic [7:0]  d;
        logic [1:0]  m;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{12'h555, 8'hAA, 2'd0}, '{12'hAAA, 8'h55, 2'd0}, '{12'h555, 8'h90, 2'd1},
        '{12'h000, 8'hF0, 2'd0}, '{12'h555, 8'hAA, 2'd0}, '{12'hAAA, 8'h56, 2'd0},
        '{12'h555, 8'h90, 2'd0}, '{12'h555, 8'hAA, 2'd0}, '{12'hABA, 8'h55, 2'd0},
        '{12'h555, 8'h90, 2'd0}, '{12'h555, 8'hAA, 2'd0}, '{12'hAAA, 8'h55, 2'd0},
        '{12'h555, 8'hA0, 2'd0}, '{12'h004, 8'h3C, 2'd2}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic c = 1'b0);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; csr_sel = c;
        @(negedge clk);
        bus_we = 1'b0; csr_sel = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v, input logic c = 1'b0);
        bus_addr = a; csr_sel = c;
        #1;
        v = bus_rdata;
        csr_sel = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55);
    endtask

    task automatic prog(input logic [11:0] a, input logic [7:0] d);
        unlock(); wr(12'h555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_setup();
        unlock(); wr(12'h555, 8'h80); unlock();
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_pin();
        hw_rst = 1'b1;
        @(negedge clk);
        hw_rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        rst = 1'b1; hw_rst = 1'b0; bus_we = 1'b0; csr_sel = 1'b0;
        bus_addr = '0; bus_wdata = '0; fail_inject = 1'b0;
        prot_cfg = 12'h208; security_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 busy", busy, 0);
        rd(12'h000, v); chk("R1 byte0", v, 8'hFF);
        rd(12'h02F, v); chk("R1 last byte", v, 8'hFF);

        // R2 R3 R7 R9 write table
        for (int i = 0; i < 14; i++) begin
            wr(VECS[i].a, VECS[i].d);
            chk($sformatf("R2/R3/R7/R9 vec%0d mode", i), mode, VECS[i].m);
        end
        wait_idle(n); chk("R2 program cycles", n, PROG);
        rd(12'h004, v); chk("R2 programmed", v, 8'h3C);
        prog(12'h004, 8'h0F); wait_idle(n);
        rd(12'h004, v); chk("R2 AND semantics", v, 8'h0C);

        // R7 readout mode
        unlock(); wr(12'h555, 8'h90);
        rd(12'h000, v); chk("R7 mfr", v, MFR);
        rd(12'h001, v); chk("R7 dev", v, DEV);
        rd(12'h002, v); chk("R7 reg A", v, 8'h08);
        rd(12'h003, v); chk("R7 reg B", v, 8'h82);
        prog(12'h004, 8'h00);
        chk("R7 program ignored in readout", mode, 1);
        wr(12'h000, 8'hF0); chk("R9 reset leaves readout", mode, 0);
        rd(12'h004, v); chk("R7 data kept", v, 8'h0C);

        // R8 register view
        rd(12'h000, v, 1'b1); chk("R8 reg A", v, 8'h08);
        rd(12'h001, v, 1'b1); chk("R8 reg B", v, 8'h82);
        wr(12'h555, 8'hAA, 1'b1); wr(12'hAAA, 8'h55); wr(12'h555, 8'h90);
        chk("R8 csr write ignored", mode, 0);

        // R4 protection and range
        prog(12'h00C, 8'h00);
        chk("R4 protected prog busy", busy, 0);
        rd(12'h00C, v); chk("R4 protected data", v, 8'hFF);
        erase_setup(); wr(12'h024, 8'h30);
        chk("R4 protected erase busy", busy, 0);
        prog(12'h555, 8'h00);
        chk("R4 out of range prog", busy, 0);

        // R5 sector erase
        prog(12'h008, 8'h11); wait_idle(n);
        erase_setup(); wr(12'h005, 8'h30);
        wait_idle(n); chk("R5 erase cycles", n, SER);
        rd(12'h004, v); chk("R5 sector erased", v, 8'hFF);
        rd(12'h008, v); chk("R5 neighbour kept", v, 8'h11);

        // R9 reset ignored during program
        prog(12'h010, 8'h22);
        wr(12'h000, 8'hF0);
        wait_idle(n); chk("R9 program remaining", n, PROG - 1);
        rd(12'h010, v); chk("R9 program done", v, 8'h22);

        // R10 reset aborts sector erase
        prog(12'h014, 8'h33); wait_idle(n);
        erase_setup(); wr(12'h014, 8'h30);
        repeat (3) @(negedge clk);
        wr(12'h000, 8'hF0);
        wait_idle(n); chk("R10 recovery cycles", n, REC);
        rd(12'h014, v); chk("R10 sector kept", v, 8'h33);

        // R11 failure
        fail_inject = 1'b1;
        prog(12'h014, 8'h00); wait_idle(n);
        chk("R11 error mode", mode, 3);
        rd(12'h014, v); chk("R13 status in error", v, 8'h20);
        fail_inject = 1'b0;
        repeat (3) @(negedge clk);
        wr(12'h555, 8'hAA);
        chk("R11 error sticky", mode, 3);
        wr(12'h000, 8'hF0);
        wait_idle(n); chk("R11 recovery cycles", n, REC);
        chk("R11 back to read", mode, 0);
        rd(12'h014, v); chk("R11 array unchanged", v, 8'h33);

        // R12 pin abort
        prog(12'h018, 8'h00);
        @(negedge clk);
        pulse_pin();
        rd(12'h018, v); chk("R13 status while busy", v, 8'h80);
        wait_idle(n); chk("R12 recovery cycles", n, REC);
        rd(12'h018, v); chk("R12 no change", v, 8'hFF);
        unlock(); wr(12'h555, 8'h90); pulse_pin();
        chk("R12 readout cleared", mode, 0);
        fail_inject = 1'b1; prog(12'h018, 8'h00); wait_idle(n); fail_inject = 1'b0;
        pulse_pin();
        chk("R12 error cleared", mode, 0);

        // R6 bulk erase with reset ignored
        prot_cfg = 12'h200;
        prog(12'h00C, 8'h44); wait_idle(n);
        prot_cfg = 12'h208;
        erase_setup(); wr(12'h555, 8'h10);
        repeat (5) @(negedge clk);
        wr(12'h000, 8'hF0);
        wait_idle(n); chk("R6/R9 bulk remaining", n, BER - 6);
        rd(12'h00C, v); chk("R6 protected kept", v, 8'h44);
        rd(12'h010, v); chk("R6 sector4 erased", v, 8'hFF);
        rd(12'h008, v); chk("R6 sector2 erased", v, 8'hFF);
        rd(12'h014, v); chk("R6 sector5 erased", v, 8'hFF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule